// File: doc/BRIEF.md
# Aliased Control Register Bank

This block is a bank of 64-bit configuration and control words that hangs off a word-oriented register bus as a slave. A requester presents one access per cycle with a valid strobe, a read/write select, a byte address, an access size in bytes and write data. One clock later the bank answers with a response strobe, the read word and three mutually exclusive error flags.

The bank holds six control words, two configuration words, a status word, a mask word, a protection word and a lock word. The control and configuration words each answer at three word indices. The base index overwrites the word. An index 0x10 higher ORs the data into the word. An index 0x20 higher clears the bits that are set in the data. Software can therefore change single bits without a read-modify-write. The two alias indices cannot be read. The remaining four words are plain read/write words.

Bus words are big-endian: the byte at the lowest address travels in bits 63:56. The bank stores and returns words unchanged, so no byte swapping takes place inside it.

Top module: `cregs_bank`

## Requirements
- R1: After a synchronous active-high reset every stored word reads as zero and `rsp_vld` is low until a request is made.
- R2: Each cycle with `req_vld` high produces exactly one `rsp_vld` pulse in the following cycle. A cycle without a request produces none. `rsp_rdata` is zero for writes and for any response that carries an error flag. At most one error flag is set per response.
- R3: The word index is the byte address shifted right by 3. Indices 0x00 to 0x05 overwrite control word i on a write and return control word i on a read.
- R4: A write to index 0x10+i (i in 0..5) sets control word i to its old value OR the write data.
- R5: A write to index 0x20+i (i in 0..5) sets control word i to its old value AND NOT the write data.
- R6: A read of any OR-alias or clear-alias index (0x10 to 0x15, 0x18, 0x19, 0x20 to 0x25, 0x28, 0x29) raises `rsp_wo_err`, returns zero and leaves every word unchanged.
- R7: Configuration word 0 is overwritten at 0x08, OR-set at 0x18 and cleared at 0x28. Configuration word 1 uses 0x09, 0x19 and 0x29 in the same way. Both read back at 0x08 and 0x09.
- R8: Status (0x100), mask (0x101), protection (0x3FE) and lock (0x3FF) are plain read/write words.
- R9: An access to any other index raises `rsp_undec_err`. A read there returns zero, and a write there changes no word.
- R10: An access whose size is not 8 or whose byte address has a nonzero low three bits raises `rsp_fmt_err` and changes no word. This flag takes priority over the other two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address (word index in bits 12:3) |
| req_size | input | 4 | Access size in bytes; only 8 is legal |
| req_wdata | input | 64 | Write data, big-endian byte order |
| rsp_vld | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read word, zero for writes and errors |
| rsp_wo_err | output | 1 | Read of a write-only alias |
| rsp_undec_err | output | 1 | Access to an undecoded index |
| rsp_fmt_err | output | 1 | Bad size or misaligned address |

## Verification
Every result of this bank appears one clock after the request that causes it. This covers the response strobe, the read word and the error flags, all of which come from a single output register stage. A word changed by a write is visible to a read issued in the very next cycle. The bench drives each request on a falling edge and lets one rising edge capture it. It samples the response on the next falling edge, where the outputs of that request and no other are present. It updates its model only after that sample, so the next access compares against the post-write state.

// File: rtl/cregs_pkg.sv
package cregs_pkg;

  // Alias operation, encoded exactly as index bits [5:4] of an aliased word
  typedef enum logic [1:0] {
    OP_OVR = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2
  } alias_op_e;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ALIAS = 2'd1,
    TGT_PLAIN = 2'd2
  } tgt_e;

  localparam int unsigned SLOT_W = 3;

  typedef struct packed {
    tgt_e              tgt;
    alias_op_e         op;
    logic [SLOT_W-1:0] slot;
  } dec_t;

  // Fixed word indices
  localparam int unsigned CFG0_LOW   = 8;
  localparam int unsigned CFG1_LOW   = 9;
  localparam int unsigned STAT_IDX   = 'h100;
  localparam int unsigned MASK_IDX   = 'h101;
  localparam int unsigned PROT_IDX   = 'h3FE;
  localparam int unsigned LOCK_IDX   = 'h3FF;
  localparam int unsigned N_PLAIN    = 4;

endpackage

// File: rtl/cregs_decode.sv
module cregs_decode
  import cregs_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned N_CTRL = 6
) (
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);

  logic       low_page;
  logic [3:0] low_nib;
  logic [1:0] grp;

  assign low_page = (idx[IDX_W-1:6] == '0);
  assign low_nib  = idx[3:0];
  assign grp      = idx[5:4];

  always_comb begin
    dec.tgt  = TGT_NONE;
    dec.op   = OP_OVR;
    dec.slot = '0;
    if (low_page && grp != 2'd3) begin
      dec.op = alias_op_e'(grp);
      if (32'(low_nib) < N_CTRL) begin
        dec.tgt  = TGT_ALIAS;
        dec.slot = SLOT_W'(low_nib);
      end else if (32'(low_nib) == CFG0_LOW) begin
        dec.tgt  = TGT_ALIAS;
        dec.slot = SLOT_W'(N_CTRL);
      end else if (32'(low_nib) == CFG1_LOW) begin
        dec.tgt  = TGT_ALIAS;
        dec.slot = SLOT_W'(N_CTRL + 1);
      end
    end else begin
      dec.op = OP_OVR;
      if (32'(idx) == STAT_IDX) begin
        dec.tgt = TGT_PLAIN; dec.slot = SLOT_W'(0);
      end else if (32'(idx) == MASK_IDX) begin
        dec.tgt = TGT_PLAIN; dec.slot = SLOT_W'(1);
      end else if (32'(idx) == PROT_IDX) begin
        dec.tgt = TGT_PLAIN; dec.slot = SLOT_W'(2);
      end else if (32'(idx) == LOCK_IDX) begin
        dec.tgt = TGT_PLAIN; dec.slot = SLOT_W'(3);
      end
    end
  end

endmodule

// File: rtl/cregs_cell.sv
module cregs_cell
  import cregs_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  alias_op_e         op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_en) begin
      unique case (op)
        OP_OVR:  q <= wdata;
        OP_SET:  q <= q | wdata;
        OP_CLR:  q <= q & ~wdata;
        default: q <= q;
      endcase
    end
  end

endmodule

// File: rtl/cregs_bank.sv
module cregs_bank
  import cregs_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned N_CTRL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_wo_err,
  output logic              rsp_undec_err,
  output logic              rsp_fmt_err
);

  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam int unsigned OFS_W      = $clog2(WORD_BYTES);
  localparam int unsigned IDX_W      = ADDR_W - OFS_W;
  localparam int unsigned N_ALIAS    = N_CTRL + 2;
  localparam int unsigned AL_SW      = $clog2(N_ALIAS);
  localparam int unsigned PL_SW      = $clog2(N_PLAIN);

  logic [IDX_W-1:0]  idx;
  dec_t              dec;
  logic              fmt_bad;
  logic              acc_ok;
  logic              wr_go;
  logic [DATA_W-1:0] alias_q [N_ALIAS];
  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] rd_val;
  logic              wo_hit;
  logic              undec_hit;

  assign idx     = req_addr[ADDR_W-1:OFS_W];
  assign fmt_bad = (req_size != SIZE_W'(WORD_BYTES)) || (req_addr[OFS_W-1:0] != '0);
  assign acc_ok  = req_vld && !fmt_bad;
  assign wr_go   = acc_ok && req_we;

  cregs_decode #(
    .IDX_W  (IDX_W),
    .N_CTRL (N_CTRL)
  ) dec_i (
    .idx (idx),
    .dec (dec)
  );

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
    cregs_cell #(.DATA_W(DATA_W)) cell_i (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_go && dec.tgt == TGT_ALIAS && dec.slot == SLOT_W'(g)),
      .op    (dec.op),
      .wdata (req_wdata),
      .q     (alias_q[g])
    );
  end

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    cregs_cell #(.DATA_W(DATA_W)) cell_i (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_go && dec.tgt == TGT_PLAIN && dec.slot == SLOT_W'(g)),
      .op    (OP_OVR),
      .wdata (req_wdata),
      .q     (plain_q[g])
    );
  end

  always_comb begin
    rd_val    = '0;
    wo_hit    = 1'b0;
    undec_hit = 1'b0;
    if (acc_ok) begin
      unique case (dec.tgt)
        TGT_ALIAS: begin
          if (dec.op != OP_OVR) wo_hit = !req_we;
          else if (!req_we)     rd_val = alias_q[dec.slot[AL_SW-1:0]];
        end
        TGT_PLAIN: begin
          if (!req_we) rd_val = plain_q[dec.slot[PL_SW-1:0]];
        end
        default: undec_hit = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld       <= 1'b0;
      rsp_rdata     <= '0;
      rsp_wo_err    <= 1'b0;
      rsp_undec_err <= 1'b0;
      rsp_fmt_err   <= 1'b0;
    end else begin
      rsp_vld       <= req_vld;
      rsp_rdata     <= rd_val;
      rsp_wo_err    <= wo_hit;
      rsp_undec_err <= undec_hit;
      rsp_fmt_err   <= req_vld && fmt_bad;
    end
  end

endmodule

// File: rtl/cregs_bank_chk.sv
module cregs_bank_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned SIZE_W = 4,
  parameter int unsigned N_CTRL = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_vld,
  input logic              req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_vld,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_wo_err,
  input logic              rsp_undec_err,
  input logic              rsp_fmt_err
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> rsp_vld);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !rsp_vld);

  // R2
  single_err_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_wo_err, rsp_undec_err, rsp_fmt_err}));

  // R2
  err_needs_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_wo_err || rsp_undec_err || rsp_fmt_err) |-> rsp_vld);

  // R2
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_wo_err || rsp_undec_err || rsp_fmt_err) |-> (rsp_rdata == '0));

  // R2
  write_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_we) |=> (rsp_rdata == '0));

  // R10
  fmt_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && (req_size != SIZE_W'(DATA_W / 8) || req_addr[2:0] != 3'd0)) |=> rsp_fmt_err);

  // R6
  wo_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_we) |=> !rsp_wo_err);

endmodule

bind cregs_bank cregs_bank_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .SIZE_W (SIZE_W),
  .N_CTRL (N_CTRL)
) chk_i (.*);

// File: tb/cregs_bank_tb_top.sv
`timescale 1ns/1ps
module cregs_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic        req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_vld;
  logic [63:0] rsp_rdata;
  logic        rsp_wo_err;
  logic        rsp_undec_err;
  logic        rsp_fmt_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] m_al [8];
  logic [63:0] m_pl [4];

  always #2 clk = ~clk;

  cregs_bank dut_i (
    .clk (clk), .rst (rst),
    .req_vld (req_vld), .req_we (req_we), .req_addr (req_addr),
    .req_size (req_size), .req_wdata (req_wdata),
    .rsp_vld (rsp_vld), .rsp_rdata (rsp_rdata),
    .rsp_wo_err (rsp_wo_err), .rsp_undec_err (rsp_undec_err),
    .rsp_fmt_err (rsp_fmt_err)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Bench view of the map: kind 0 none, 1 aliased (slot, op), 2 plain (slot)
  task automatic classify(input logic [12:0] addr, output int kind,
                          output int slot, output int op, output string tag);
    int ix = int'(addr >> 3);
    kind = 0; slot = 0; op = 0; tag = "R9";
    case (ix)
      'h100: begin kind = 2; slot = 0; tag = "R8"; end
      'h101: begin kind = 2; slot = 1; tag = "R8"; end
      'h3FE: begin kind = 2; slot = 2; tag = "R8"; end
      'h3FF: begin kind = 2; slot = 3; tag = "R8"; end
      default: begin
        if (ix < 'h30) begin
          op = ix / 16;
          if ((ix % 16) < 6) begin
            kind = 1; slot = ix % 16;
            tag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R5";
          end else if ((ix % 16) == 8 || (ix % 16) == 9) begin
            kind = 1; slot = (ix % 16) - 2; tag = "R7";
          end
        end
      end
    endcase
  endtask

  task automatic access(input logic we, input logic [12:0] addr,
                        input logic [3:0] size, input logic [63:0] data);
    int kind, slot, op;
    string tag;
    logic [63:0] e_rd;
    logic [2:0]  e_fl;
    classify(addr, kind, slot, op, tag);
    e_rd = '0;
    e_fl = 3'b000;
    if (size != 4'd8 || addr[2:0] != 3'd0) begin
      e_fl = 3'b001; tag = "R10";
    end else if (kind == 0) begin
      e_fl = 3'b010;
    end else if (kind == 1 && op != 0 && !we) begin
      e_fl = 3'b100; tag = "R6";
    end else if (!we) begin
      e_rd = (kind == 1) ? m_al[slot] : m_pl[slot];
    end
    req_vld = 1'b1; req_we = we; req_addr = addr; req_size = size; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "rsp_vld", 64'(rsp_vld), 64'd1);
    chk(tag, "rdata", rsp_rdata, e_rd);
    chk(tag, "flags wo/undec/fmt", 64'({rsp_wo_err, rsp_undec_err, rsp_fmt_err}), 64'(e_fl));
    req_vld = 1'b0;
    if (we && e_fl == 3'b000) begin
      if (kind == 2) m_pl[slot] = data;
      else if (op == 0) m_al[slot] = data;
      else if (op == 1) m_al[slot] = m_al[slot] | data;
      else m_al[slot] = m_al[slot] & ~data;
    end
  endtask

  function automatic logic [12:0] a_of(input int ix);
    return 13'(ix << 3);
  endfunction

  function automatic int pick_idx(input int unsigned r);
    int pool [28] = '{0,1,2,3,4,5,8,9,'h10,'h13,'h15,'h18,'h19,'h20,'h22,'h25,'h28,'h29,
                      6,7,'h16,'h1A,'h30,'h100,'h101,'h3FE,'h3FF,'h102};
    if (r % 8 == 7) return int'($urandom % 1024);
    return pool[(r / 8) % 28];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) m_al[i] = '0;
    for (int i = 0; i < 4; i++) m_pl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset, every word zero
    chk("R1", "rsp_vld idle", 64'(rsp_vld), 64'd0);
    for (int i = 0; i < 6; i++) access(1'b0, a_of(i), 4'd8, '0);
    access(1'b0, a_of(8), 4'd8, '0);
    access(1'b0, a_of(9), 4'd8, '0);
    access(1'b0, a_of('h100), 4'd8, '0);
    access(1'b0, a_of('h101), 4'd8, '0);
    access(1'b0, a_of('h3FE), 4'd8, '0);
    access(1'b0, a_of('h3FF), 4'd8, '0);

    // R3 R4 R5 directed on control word 3
    access(1'b1, a_of(3), 4'd8, 64'h00F0_00F0_1234_0000);
    access(1'b1, a_of('h13), 4'd8, 64'h0F00_0000_0000_00FF);
    access(1'b0, a_of(3), 4'd8, '0);
    access(1'b1, a_of('h23), 4'd8, 64'h00F0_0000_1200_000F);
    access(1'b0, a_of(3), 4'd8, '0);
    // R6: reads of aliases reject, word untouched
    access(1'b0, a_of('h13), 4'd8, '0);
    access(1'b0, a_of('h23), 4'd8, '0);
    access(1'b0, a_of(3), 4'd8, '0);
    // R7 on configuration word 1
    access(1'b1, a_of(9), 4'd8, 64'hAAAA_0000_0000_5555);
    access(1'b1, a_of('h19), 4'd8, 64'h0000_FFFF_0000_0000);
    access(1'b1, a_of('h29), 4'd8, 64'hA000_0F00_0000_0005);
    access(1'b0, a_of(9), 4'd8, '0);
    access(1'b0, a_of('h29), 4'd8, '0);
    // R9: undecoded write leaves neighbours, read returns zero
    access(1'b1, a_of(6), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    access(1'b0, a_of(6), 4'd8, '0);
    access(1'b1, a_of('h1A), 4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    access(1'b0, a_of(5), 4'd8, '0);
    // R10: bad size and misalignment change nothing
    access(1'b1, a_of(3), 4'd4, 64'h1111_1111_1111_1111);
    access(1'b1, a_of(3) | 13'd4, 4'd8, 64'h2222_2222_2222_2222);
    access(1'b0, a_of(3) | 13'd1, 4'd8, '0);
    access(1'b0, a_of(3), 4'd8, '0);
    // R8 plain words
    access(1'b1, a_of('h3FF), 4'd8, 64'hDEAD_BEEF_0000_0001);
    access(1'b0, a_of('h3FF), 4'd8, '0);
    // R2: no response without request
    @(negedge clk);
    chk("R2", "rsp_vld idle", 64'(rsp_vld), 64'd0);

    for (int i = 0; i < 600; i++) begin
      int unsigned r  = $urandom;
      int ix          = pick_idx(r);
      logic [12:0] ad = a_of(ix);
      logic [3:0] sz  = 4'd8;
      logic [63:0] d  = {$urandom, $urandom};
      if ($urandom % 16 == 0) sz = 4'($urandom % 8);
      if ($urandom % 16 == 0) ad = ad | 13'($urandom % 8);
      access(1'($urandom % 2), ad, sz, d);
    end

    for (int i = 0; i < 6; i++) access(1'b0, a_of(i), 4'd8, '0);
    access(1'b0, a_of(8), 4'd8, '0);
    access(1'b0, a_of(9), 4'd8, '0);
    access(1'b0, a_of('h100), 4'd8, '0);
    access(1'b0, a_of('h101), 4'd8, '0);
    access(1'b0, a_of('h3FE), 4'd8, '0);
    finish_run();
  end

endmodule